// File: doc/BRIEF.md
# Activity-Gated 16-Bit Pseudo-Random Bit Generator

This block produces a repeatable pseudo-random bit stream from a 16-bit Fibonacci-style shift register with XOR feedback. Each storage bit is written on a step only when its new value differs from the value it already holds. Bits whose value would stay the same get no write enable. This lowers switching activity in the register array, and the state sequence stays the same as in a register that updates every bit on every clock.

A seed strobe loads all 16 bits in one cycle. It bypasses the per-bit gating and takes priority over stepping. An all-zero seed would lock the register at zero, so the block stores 16'h0001 in its place. A run input advances the sequence by one step per clock. A registered activity count reports how many bits were written by the most recent step, so a testbench or power monitor can observe how well the gating works.

Top module: `lfsr_gated_gen`

## Requirements
- R1: While reset is asserted, and until the first load or step after reset, the state is 16'hACE1, the serial output is 1, and the activity count is 0.
- R2: On a clock edge with run high and seed_load low, state bits [14:0] take the old bits [15:1], and bit 15 takes the XOR of old bits 0, 2, 3 and 5. This is polynomial x^16+x^14+x^13+x^11+1, with its tap positions counted from bit 15 as position 1.
- R3: The serial output always equals state bit 0, the rightmost stage.
- R4: On a clock edge with seed_load high and a non-zero seed, all 16 bits take the seed, whatever the value of run.
- R5: On a clock edge with seed_load high and a zero seed, the state becomes 16'h0001.
- R6: On a clock edge with seed_load and run both low, the state holds and the activity count becomes 0.
- R7: After a step, the activity count equals the number of state bits that changed in that step. After a load cycle it reads 0.
- R8: For any non-zero seed, the state returns to the seed after exactly 65535 steps, does not return earlier, and never reaches zero.
- R9: Loading the same seed twice produces the same output sequence both times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| seed_load | input | 1 | Loads seed into all state bits on the next edge |
| seed | input | 16 | Seed value; zero is replaced by 16'h0001 |
| run | input | 1 | Advances the sequence by one step per clock |
| bit_out | output | 1 | Serial pseudo-random output (state bit 0) |
| state_out | output | 16 | Full register state |
| upd_count | output | 5 | Number of bits written by the most recent step |

## Verification
A seed load and a run step can be requested on the same edge. The bench provokes this with directed cycles where both inputs are high, including one with a zero seed, and with random cycles where both strobes are drawn independently. In each such cycle it checks that the state equals the loaded seed (or 16'h0001), not the stepped value, and that the activity count reads zero. The expected values come from a bench model that gives the load priority.

// File: rtl/lfsr_gen_pkg.sv
package lfsr_gen_pkg;
  localparam int unsigned LFSR_W = 16;
  // Feedback taps as state indices; bit i set means state[i] feeds the XOR
  localparam logic [LFSR_W-1:0] TAP_MASK_DEF = 16'h002D;
  localparam logic [LFSR_W-1:0] RESET_SEED_DEF = 16'hACE1;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'b00,
    ACT_SHIFT = 2'b01,
    ACT_LOAD  = 2'b10
  } act_e;
endpackage

// File: rtl/lfsr_rst_sync.sv
module lfsr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl
  import lfsr_gen_pkg::*;
#(
  parameter int unsigned WIDTH = LFSR_W
) (
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed,
  input  logic             run,
  output logic             load_en,
  output logic             shift_en,
  output logic [WIDTH-1:0] load_val
);
  localparam logic [WIDTH-1:0] SAFE_SEED = {{(WIDTH-1){1'b0}}, 1'b1};

  act_e act;

  always_comb begin
    if (seed_load)      act = ACT_LOAD;
    else if (run)       act = ACT_SHIFT;
    else                act = ACT_IDLE;
  end

  always_comb begin
    load_en  = (act == ACT_LOAD);
    shift_en = (act == ACT_SHIFT);
    load_val = (seed == '0) ? SAFE_SEED : seed;
  end
endmodule

// File: rtl/lfsr_feedback.sv
module lfsr_feedback
  import lfsr_gen_pkg::*;
#(
  parameter int unsigned     WIDTH    = LFSR_W,
  parameter logic [WIDTH-1:0] TAP_MASK = TAP_MASK_DEF
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  logic fb;

  always_comb begin
    fb  = ^(cur & TAP_MASK);
    nxt = {fb, cur[WIDTH-1:1]};
  end
endmodule

// File: rtl/lfsr_bit_cell.sv
module lfsr_bit_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic load_bit,
  input  logic shift_en,
  input  logic d,
  output logic q,
  output logic upd
);
  logic wr_en;
  logic q_nxt;

  // Per-bit gate: write only when the step would change this bit
  always_comb begin
    upd   = shift_en & (d ^ q);
    wr_en = load_en | upd;
    q_nxt = load_en ? load_bit : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (wr_en) begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/lfsr_activity.sv
module lfsr_activity #(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] upd,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = '0;
    for (int i = 0; i < int'(WIDTH); i++) begin
      cnt_nxt = cnt_nxt + CNT_W'(upd[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/lfsr_gated_gen.sv
module lfsr_gated_gen
  import lfsr_gen_pkg::*;
#(
  parameter int unsigned      WIDTH      = LFSR_W,
  parameter logic [WIDTH-1:0] TAP_MASK   = TAP_MASK_DEF,
  parameter logic [WIDTH-1:0] RESET_SEED = RESET_SEED_DEF,
  localparam int unsigned     CNT_W      = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed,
  input  logic             run,
  output logic             bit_out,
  output logic [WIDTH-1:0] state_out,
  output logic [CNT_W-1:0] upd_count
);
  logic             rst_q;
  logic             load_en;
  logic             shift_en;
  logic [WIDTH-1:0] load_val;
  logic [WIDTH-1:0] state;
  logic [WIDTH-1:0] state_nxt;
  logic [WIDTH-1:0] upd;

  lfsr_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q)
  );

  lfsr_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .seed_load (seed_load),
    .seed      (seed),
    .run       (run),
    .load_en   (load_en),
    .shift_en  (shift_en),
    .load_val  (load_val)
  );

  lfsr_feedback #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_fb (
    .cur (state),
    .nxt (state_nxt)
  );

  for (genvar i = 0; i < int'(WIDTH); i++) begin : g_cell
    lfsr_bit_cell #(.RST_VAL(RESET_SEED[i])) u_cell (
      .clk      (clk),
      .rst_n    (rst_q),
      .load_en  (load_en),
      .load_bit (load_val[i]),
      .shift_en (shift_en),
      .d        (state_nxt[i]),
      .q        (state[i]),
      .upd      (upd[i])
    );
  end

  lfsr_activity #(.WIDTH(WIDTH)) u_act (
    .clk   (clk),
    .rst_n (rst_q),
    .upd   (upd),
    .cnt   (upd_count)
  );

  assign state_out = state;
  assign bit_out   = state[0];

  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_q)
    (run && !seed_load) |=> state_out[WIDTH-2:0] == $past(state_out[WIDTH-1:1])); // R2
  AST_LOAD_ALL: assert property (@(posedge clk) disable iff (!rst_q)
    (seed_load && seed != '0) |=> state_out == $past(seed)); // R4
  AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_q)
    (seed_load && seed == '0) |=> state_out == {{(WIDTH-1){1'b0}}, 1'b1}); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (!seed_load && !run) |=> ($stable(state_out) && upd_count == '0)); // R6
  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_q)
    (run && !seed_load) |=> upd_count == CNT_W'($countones(state_out ^ $past(state_out)))); // R7
  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_q)
    seed_load |=> upd_count == '0); // R7
  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_q)
    state_out != '0); // R8
endmodule

// File: tb/lfsr_gated_gen_bench.sv
`timescale 1ns/1ps
module lfsr_gated_gen_bench;
  logic        clk;
  logic        rst_n;
  logic        seed_load;
  logic [15:0] seed;
  logic        run;
  logic        bit_out;
  logic [15:0] state_out;
  logic [4:0]  upd_count;

  int n_cmp;
  int n_bad;
  logic [15:0] exp_state;
  logic [4:0]  exp_cnt;
  logic        rep_a [48];
  bit          done;

  lfsr_gated_gen u_lfsr_gated_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_load (seed_load),
    .seed      (seed),
    .run       (run),
    .bit_out   (bit_out),
    .state_out (state_out),
    .upd_count (upd_count)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] ref_next(input logic [15:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
  endfunction

  function automatic logic [4:0] ones(input logic [15:0] v);
    logic [4:0] c = '0;
    for (int i = 0; i < 16; i++) c = c + 5'(v[i]);
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic ld, input logic [15:0] sd, input logic rn);
    logic [15:0] nx;
    @(negedge clk);
    seed_load = ld;
    seed      = sd;
    run       = rn;
    @(posedge clk);
    #1;
    if (ld) begin
      exp_state = (sd == 16'h0) ? 16'h0001 : sd;
      exp_cnt   = '0;
      check((sd == 16'h0) ? "R5 zero seed" : "R4 load", 32'(state_out), 32'(exp_state));
      check("R7 count after load", 32'(upd_count), 32'(exp_cnt));
    end else if (rn) begin
      nx        = ref_next(exp_state);
      exp_cnt   = ones(nx ^ exp_state);
      exp_state = nx;
      check("R2 step", 32'(state_out), 32'(exp_state));
      check("R7 count", 32'(upd_count), 32'(exp_cnt));
    end else begin
      exp_cnt = '0;
      check("R6 idle hold", 32'(state_out), 32'(exp_state));
      check("R6 idle count", 32'(upd_count), 32'(exp_cnt));
    end
    check("R3 serial", 32'(bit_out), 32'(exp_state[0]));
  endtask

  initial begin
    done = 1'b0;
    #(4 * 190000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned rs;
    int returns;
    n_cmp = 0;
    n_bad = 0;
    rs = $urandom(32'd20240917);
    rst_n = 1'b0;
    seed_load = 1'b0;
    seed = '0;
    run = 1'b0;
    exp_state = 16'hACE1;
    exp_cnt = '0;
    repeat (4) @(posedge clk);
    #1;
    check("R1 reset state", 32'(state_out), 32'h0000ACE1);
    check("R1 reset count", 32'(upd_count), 32'h0);
    check("R1 reset serial", 32'(bit_out), 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 16'h0, 1'b0);
    check("R1 state after release", 32'(state_out), 32'h0000ACE1);

    // Stepping from the reset value
    repeat (24) step(1'b0, 16'h0, 1'b1);
    repeat (4) step(1'b0, 16'h0, 1'b0);

    // Zero seed, and load coinciding with run
    step(1'b1, 16'h0000, 1'b0);
    repeat (5) step(1'b0, 16'h0, 1'b1);
    step(1'b1, 16'h0000, 1'b1);
    step(1'b1, 16'h8000, 1'b1);
    repeat (20) step(1'b0, 16'h0, 1'b1);
    step(1'b1, 16'hFFFF, 1'b1);
    repeat (20) step(1'b0, 16'h0, 1'b1);

    // R9 repeatability
    step(1'b1, 16'h1234, 1'b0);
    for (int k = 0; k < 48; k++) begin
      step(1'b0, 16'h0, 1'b1);
      rep_a[k] = bit_out;
    end
    repeat (30) step(1'b0, 16'h0, 1'b1);
    step(1'b1, 16'h1234, 1'b0);
    for (int k = 0; k < 48; k++) begin
      step(1'b0, 16'h0, 1'b1);
      check("R9 repeat sequence", 32'(bit_out), 32'(rep_a[k]));
    end

    // Random mix of loads, steps and idles
    for (int k = 0; k < 4000; k++) begin
      logic       ld;
      logic       rn;
      logic [15:0] sd;
      ld = ($urandom % 16) == 0;
      rn = ($urandom % 4) != 0;
      sd = (($urandom % 8) == 0) ? 16'h0 : 16'($urandom);
      step(ld, sd, rn);
    end

    // R8 full period
    step(1'b1, 16'hBEEF, 1'b0);
    returns = 0;
    for (int k = 1; k <= 65535; k++) begin
      @(negedge clk);
      seed_load = 1'b0;
      run = 1'b1;
      @(posedge clk);
      #1;
      exp_state = ref_next(exp_state);
      if (state_out == 16'h0) check("R8 reached zero", 32'(state_out), 32'h1);
      if (k < 65535 && state_out == 16'hBEEF) returns++;
      if (state_out !== exp_state) check("R8 period sequence", 32'(state_out), 32'(exp_state));
    end
    check("R8 early return", 32'(returns), 32'h0);
    check("R8 period end", 32'(state_out), 32'h0000BEEF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule